// File: doc/BRIEF.md
# Private Interrupt Line Conditioner

This block sits between a group of cores and an interrupt distribution stage. Each core drives a bank of private interrupt wires, 8, 12 or 16 per core, with the same count for every core. Each wire may come from a different clock domain and may follow either active level. A build-time setting for each line decides its polarity and whether it passes through a two-flop synchronizer or through a single capture flop. The conditioned result is presented as a registered vector in which a 1 always means asserted.

A wake output for each core is formed without any clock from the raw wires, after polarity correction. A power logic block can use it to restart a gated clock. Lines that carry short edge-type events can be given a hold stage at build time. This stage is set asynchronously by the event, so a pulse that arrives and ends while the local clock is stopped is still delivered once the clock runs again. An incoming active-low low-power request is passed through its own two-flop synchronizer.

Top module: `prv_irq_cond`

## Requirements
- R1: A rising edge with `rst` high leaves every bit of `irq_q_o` at 0 and `lp_req_n_o` at 1, whatever the inputs are doing.
- R2: A line whose `HIGH_MASK` bit is 0 counts as asserted when its raw wire is 0. A line whose bit is 1 counts as asserted when its wire is 1. `irq_q_o` always reports an asserted line as 1.
- R3: On a line whose `SYNC_MASK` bit is 1 and whose `HOLD_MASK` bit is 0, a change on the raw wire reaches `irq_q_o` after exactly two rising edges.
- R4: On a line whose `SYNC_MASK` bit is 0 and whose `HOLD_MASK` bit is 0, a change on the raw wire reaches `irq_q_o` after exactly one rising edge.
- R5: `wake_o[c]` is 1 exactly when any line of core c (bits `c*LINES` to `c*LINES+LINES-1` of `irq_raw_i`) is asserted per R2. It responds with no clock edge, and it responds while the clock is stopped.
- R6: `lp_req_n_o` equals `lp_req_n_i` delayed by exactly two rising edges.
- R7: On a line whose `HOLD_MASK` bit is 1, an assertion that begins and ends while the clock is stopped is held. Once the clock restarts, it appears on `irq_q_o` with the latency of R3 or R4.
- R8: A held event that is shorter than one clock period produces exactly one contiguous assertion on `irq_q_o`. This assertion lasts 3 cycles on a synchronized line and 2 cycles on a capture-flop line, after which the hold stage releases.
- R9: On a line whose `HOLD_MASK` bit is 0, an assertion that begins and ends while the clock is stopped never appears on `irq_q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; may be stopped by an outside gate |
| rst | input | 1 | Synchronous reset, active high |
| irq_raw_i | input | NUM_CORES*LINES | Raw private interrupt wires; core c owns bits c*LINES upward |
| lp_req_n_i | input | 1 | Asynchronous low-power request, active low |
| irq_q_o | output | NUM_CORES*LINES | Conditioned, registered lines, 1 = asserted |
| wake_o | output | NUM_CORES | Combinational activity for each core, to be treated as asynchronous |
| lp_req_n_o | output | 1 | Synchronized low-power request, active low |

## Verification
The bench builds the block with two cores of 12 lines each. It uses mixed masks: `HIGH_MASK` 24'h5AC3F0, `SYNC_MASK` 24'h330F55 and `HOLD_MASK` 24'hF00000. With these values, every combination of polarity and synchronizer choice appears on the lines without a hold stage. The sweep with back-to-back vector changes therefore separates the one-cycle and two-cycle paths bit by bit. Core 1's upper lines give a held line in each of the active-high synchronized, active-low synchronized and active-high capture forms, next to an unheld line. This makes it possible to stop the clock, pulse the lines and compare the held and dropped cases after restart. The count of 12 lines also checks that the wake grouping follows a line count that is not a power of two.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Build-time options carried by each conditioned line
    typedef struct packed {
        logic act_high;   // 1: wire is asserted high; 0: asserted low
        logic two_stage;  // 1: two-flop synchronizer; 0: single capture flop
        logic hold;       // 1: asynchronous event hold in front of the flops
    } line_opt_t;

    localparam int SYNC_DEPTH = 2;

    function automatic line_opt_t make_opt(input logic hi, input logic sy, input logic ho);
        line_opt_t o;
        o.act_high  = hi;
        o.two_stage = sy;
        o.hold      = ho;
        return o;
    endfunction

    // Map a raw wire onto the internal active-high meaning
    function automatic logic to_internal(input logic raw, input logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/pic_hold.sv
module pic_hold (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic seen_i,
    output logic hold_o
);
    // Set without a clock so events survive a stopped clock; cleared once
    // the downstream register has shown the event on a rising edge.
    always_ff @(posedge clk or posedge evt_i) begin
        if (evt_i)
            hold_o <= 1'b1;
        else if (rst)
            hold_o <= 1'b0;
        else if (seen_i)
            hold_o <= 1'b0;
    end
endmodule

// File: rtl/pic_line.sv
module pic_line
    import pic_pkg::*;
#(
    parameter line_opt_t OPT = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic q_o
);
    logic feed;

    assign level_o = to_internal(raw_i, OPT.act_high);

    generate
        if (OPT.hold) begin : g_hold
            pic_hold u_hold (
                .clk    (clk),
                .rst    (rst),
                .evt_i  (level_o),
                .seen_i (q_o),
                .hold_o (feed)
            );
        end else begin : g_direct
            assign feed = level_o;
        end

        if (OPT.two_stage) begin : g_sync
            logic [SYNC_DEPTH-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else
                    chain <= {chain[SYNC_DEPTH-2:0], feed};
            end
            assign q_o = chain[SYNC_DEPTH-1];
        end else begin : g_capture
            logic cap;
            always_ff @(posedge clk) begin
                if (rst)
                    cap <= 1'b0;
                else
                    cap <= feed;
            end
            assign q_o = cap;
        end
    endgenerate
endmodule

// File: rtl/pic_lpsync.sv
module pic_lpsync #(
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst)
            stage <= {DEPTH{RST_VAL}};
        else
            stage <= {stage[DEPTH-2:0], d_i};
    end

    assign q_o = stage[DEPTH-1];
endmodule

// File: rtl/prv_irq_cond.sv
module prv_irq_cond
    import pic_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int LINES     = 8,
    parameter logic [NUM_CORES*LINES-1:0] HIGH_MASK = '0,
    parameter logic [NUM_CORES*LINES-1:0] SYNC_MASK = '1,
    parameter logic [NUM_CORES*LINES-1:0] HOLD_MASK = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CORES*LINES-1:0] irq_raw_i,
    input  logic                       lp_req_n_i,
    output logic [NUM_CORES*LINES-1:0] irq_q_o,
    output logic [NUM_CORES-1:0]       wake_o,
    output logic                       lp_req_n_o
);
    localparam int TOTAL = NUM_CORES * LINES;

    logic [TOTAL-1:0] level;

    generate
        for (genvar i = 0; i < TOTAL; i++) begin : g_line
            pic_line #(
                .OPT (make_opt(HIGH_MASK[i], SYNC_MASK[i], HOLD_MASK[i]))
            ) u_line (
                .clk     (clk),
                .rst     (rst),
                .raw_i   (irq_raw_i[i]),
                .level_o (level[i]),
                .q_o     (irq_q_o[i])
            );
        end

        for (genvar c = 0; c < NUM_CORES; c++) begin : g_wake
            assign wake_o[c] = |level[c*LINES +: LINES];
        end
    endgenerate

    pic_lpsync #(
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (1'b1)
    ) u_lp (
        .clk (clk),
        .rst (rst),
        .d_i (lp_req_n_i),
        .q_o (lp_req_n_o)
    );
endmodule

// File: rtl/prv_irq_cond_chk.sv
module prv_irq_cond_chk #(
    parameter int NUM_CORES = 2,
    parameter int LINES     = 8,
    parameter logic [NUM_CORES*LINES-1:0] HIGH_MASK = '0,
    parameter logic [NUM_CORES*LINES-1:0] SYNC_MASK = '1,
    parameter logic [NUM_CORES*LINES-1:0] HOLD_MASK = '0
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_CORES*LINES-1:0] irq_raw_i,
    input logic                       lp_req_n_i,
    input logic [NUM_CORES*LINES-1:0] irq_q_o,
    input logic                       lp_req_n_o
);
    localparam int TOTAL = NUM_CORES * LINES;

    // Asserted-high view of the wires, from the polarity rule (R2)
    logic [TOTAL-1:0] want;
    assign want = ~(irq_raw_i ^ HIGH_MASK);

    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1: state after a reset edge
    always @(negedge clk) begin
        if (rst_seen)
            a_r1_reset_state: assert (irq_q_o == '0 && lp_req_n_o == 1'b1);
    end

    generate
        for (genvar i = 0; i < TOTAL; i++) begin : g_chk
            if (!HOLD_MASK[i] && SYNC_MASK[i]) begin : g_s
                a_r3_sync_latency: assert property (@(posedge clk) disable iff (rst)
                    (!$past(rst) && !$past(rst, 2)) |-> irq_q_o[i] == $past(want[i], 2));
            end else if (!HOLD_MASK[i]) begin : g_c
                a_r4_capture_latency: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> irq_q_o[i] == $past(want[i]));
            end
        end
    endgenerate

    a_r6_lp_sync: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> lp_req_n_o == $past(lp_req_n_i, 2));

endmodule

bind prv_irq_cond prv_irq_cond_chk #(
    .NUM_CORES (NUM_CORES),
    .LINES     (LINES),
    .HIGH_MASK (HIGH_MASK),
    .SYNC_MASK (SYNC_MASK),
    .HOLD_MASK (HOLD_MASK)
) u_chk (.*);

// File: tb/prv_irq_cond_test.sv
module prv_irq_cond_test;
    localparam int NC = 2;
    localparam int NL = 12;
    localparam int W  = NC * NL;
    localparam logic [W-1:0] HI = 24'h5AC3F0;
    localparam logic [W-1:0] SY = 24'h330F55;
    localparam logic [W-1:0] HO = 24'hF00000;

    logic clk_free = 1'b0;
    logic clk_run  = 1'b1;
    logic clk;
    assign clk = clk_free & clk_run;
    always #2 clk_free = ~clk_free;   // 250 MHz

    logic          rst;
    logic [W-1:0]  raw;
    logic          lp_n;
    logic [W-1:0]  q;
    logic [NC-1:0] wake;
    logic          lp_o;

    prv_irq_cond #(
        .NUM_CORES (NC), .LINES (NL),
        .HIGH_MASK (HI), .SYNC_MASK (SY), .HOLD_MASK (HO)
    ) uut (
        .clk (clk), .rst (rst), .irq_raw_i (raw), .lp_req_n_i (lp_n),
        .irq_q_o (q), .wake_o (wake), .lp_req_n_o (lp_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [W-1:0] val;
        logic [W-1:0] mask;
        string        tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    function automatic logic [W-1:0] to_raw(input logic [W-1:0] v);
        return v ^ ~HI;   // R2: active-low lines asserted by 0
    endfunction

    // Driver: apply an asserted-high vector, check wake, queue expectations
    task automatic drive_cond(input logic [W-1:0] v);
        logic [W-1:0] vv;
        vv = v & ~HO;
        raw = to_raw(vv);
        #1;
        for (int c = 0; c < NC; c++)
            check(wake[c] == |vv[c*NL +: NL], "R5 wake per core", 64'(wake[c]), 64'(|vv[c*NL +: NL]));
        sb.push_back('{cyc + 1, vv, ~SY & ~HO, "R2,R4 capture line"});
        sb.push_back('{cyc + 2, vv, SY & ~HO, "R2,R3 synchronized line"});
    endtask

    // Monitor: compare queued expectations when their cycle arrives
    always @(negedge clk) begin : mon
        exp_t e;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            e = sb.pop_front();
            check(((q ^ e.val) & e.mask) == '0, e.tag, 64'(q & e.mask), 64'(e.val & e.mask));
        end
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
        $finish;
    end

    logic [7:0] h16, h20, h21, h22;

    initial begin
        rst  = 1'b1;
        raw  = ~HI;
        lp_n = 1'b1;
        repeat (3) @(negedge clk);
        check(q == '0, "R1 reset lines", 64'(q), 64'(0));
        check(lp_o == 1'b1, "R1 reset lp", 64'(lp_o), 64'(1));
        rst = 1'b0;

        // Level sweep: back-to-back changes expose both latencies
        @(negedge clk); drive_cond('1);
        @(negedge clk); drive_cond('0);
        for (int k = 0; k < W; k++) begin
            @(negedge clk); drive_cond(W'(1) << k);
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); drive_cond(W'($urandom));
        end
        @(negedge clk); drive_cond('0);
        repeat (3) @(negedge clk);

        // R6: low-power request synchronizer
        lp_n = 1'b0;
        @(negedge clk); check(lp_o == 1'b1, "R6 after one edge", 64'(lp_o), 64'(1));
        @(negedge clk); check(lp_o == 1'b0, "R6 after two edges", 64'(lp_o), 64'(0));
        lp_n = 1'b1;
        @(negedge clk); check(lp_o == 1'b0, "R6 release one edge", 64'(lp_o), 64'(0));
        @(negedge clk); check(lp_o == 1'b1, "R6 release two edges", 64'(lp_o), 64'(1));

        // R8: sub-cycle pulses on held lines with the clock running
        raw = to_raw(W'(1) << 20 | W'(1) << 22);
        #1 raw = ~HI;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            h20[k] = q[20];
            h22[k] = q[22];
        end
        check(h20[5:0] == 6'b001110, "R8 held sync line single 3-cycle pulse", 64'(h20[5:0]), 64'(6'b001110));
        check(h22[5:0] == 6'b000011, "R8 held capture line single 2-cycle pulse", 64'(h22[5:0]), 64'(6'b000011));

        // R7/R9: pulses entirely inside a clock stop
        @(negedge clk_free);
        clk_run = 1'b0;
        #3 raw = to_raw(W'(1) << 16 | W'(1) << 20 | W'(1) << 21 | W'(1) << 22);
        #1;
        check(wake == 2'b10, "R5 wake while clock stopped", 64'(wake), 64'(2'b10));
        #2 raw = ~HI;
        #1;
        check(wake == 2'b00, "R5 wake clears without clock", 64'(wake), 64'(0));
        #20;
        @(negedge clk_free);
        clk_run = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            h16[k] = q[16];
            h20[k] = q[20];
            h21[k] = q[21];
            h22[k] = q[22];
        end
        check(h20[5:0] == 6'b001110, "R7 held active-high sync line", 64'(h20[5:0]), 64'(6'b001110));
        check(h21[5:0] == 6'b001110, "R7 held active-low sync line", 64'(h21[5:0]), 64'(6'b001110));
        check(h22[5:0] == 6'b000011, "R7 held capture line", 64'(h22[5:0]), 64'(6'b000011));
        check(h16[5:0] == 6'b000000, "R9 unheld line drops gap pulse", 64'(h16[5:0]), 64'(0));

        // R1: reset in mid-run with lines asserted and request active
        @(negedge clk); drive_cond('1);
        lp_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(q == '0, "R1 reset clears asserted lines", 64'(q), 64'(0));
        check(lp_o == 1'b1, "R1 reset forces lp idle", 64'(lp_o), 64'(1));
        rst  = 1'b0;
        lp_n = 1'b1;
        drive_cond('1);
        @(negedge clk); drive_cond('0);
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule